// File: doc/BRIEF.md
# Clock Fanout Output Gating

This block takes one reference clock and fans it out to six output pairs, each with a true and a second output, plus one feedback output. A mode input sets what the second output of a pair does. In complementary mode it carries the inverse of the reference. In single-ended mode it carries another in-phase copy. Each pair has one enable bit that switches both of its outputs at once. The feedback output has its own enable bit. A control register interface outside this block supplies all the enable bits.

Every output is modelled as a data value plus an output-enable, which stands in for a tri-state driver. The active-low power-down input drops every output-enable, whatever the enable bits say. A disabled output does not float. It is held at a static level: low, or high for the inverted output of a pair in complementary mode. Each enable passes through a latch that is open only while the reference is low. As a result, an output never starts or stops partway through a high phase of the reference. While reset is active, the latches are forced to all ones, so every output runs from power-up.

Top module: `clk_fanout_gate`

## Requirements
- R1: While pd_ni is 0, pair_oe_o is all zeros and fb_oe_o is 0. While pd_ni is 1, pair_oe_o is all ones and fb_oe_o is 1.
- R2: With mode_i = 1 (complementary), pair_c_o[i] is the inverse of pair_t_o[i] in both phases of the reference.
- R3: With mode_i = 0 (single-ended), pair_c_o[i] equals pair_t_o[i] in both phases.
- R4: For an enabled pair, pair_t_o[i] is high during the high phase of clk_i and low during its low phase.
- R5: For a disabled pair, pair_t_o[i] is held low in both phases. pair_c_o[i] is held low in single-ended mode and high in complementary mode.
- R6: Bit i of pair_en_i gates only pair i (bit 0 maps to pair 0), and it gates both outputs of that pair together.
- R7: fb_o follows clk_i in phase when fb_en_i is 1 and is held low when fb_en_i is 0. It is never inverted, whatever mode_i is.
- R8: A change of pair_en_i or fb_en_i made while clk_i is high has no effect until clk_i goes low. A high phase that has started is therefore neither cut short nor started late.
- R9: While rst_ni is 0, every pair and the feedback output behave as enabled, whatever the enable inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock being distributed |
| rst_ni | input | 1 | Active-low asynchronous reset; forces all enables on |
| mode_i | input | 1 | 1 = complementary second output, 0 = in-phase copies |
| pd_ni | input | 1 | Active-low power-down; 0 floats every output |
| pair_en_i | input | 6 | Per-pair enable, bit i for pair i |
| fb_en_i | input | 1 | Feedback output enable |
| pair_t_o | output | 6 | True output of each pair |
| pair_c_o | output | 6 | Second output of each pair |
| pair_oe_o | output | 6 | Output-enable for both outputs of each pair |
| fb_o | output | 1 | Feedback clock output |
| fb_oe_o | output | 1 | Feedback output-enable |

## Verification
The assertions sample the outputs at each edge of clk_i. They take it that mode_i and pd_ni change only while the reference is low. They also take it that clk_i is the only thing that toggles an output within a phase. The bench drives mode_i and pd_ni just after a falling edge, so both inputs are steady at every sample. It changes the enable inputs in either phase, on purpose, so that a change during the high phase tests R8. The bench model takes each enable value at the rising edge and, while reset is active, uses ones instead.

// File: rtl/fanout_pkg.sv
package fanout_pkg;
  parameter int unsigned FANOUT_PAIRS = 6;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_COMPL  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/clk_en_latch.sv
// Enable latches, open only while the reference clock is low.
module clk_en_latch #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] en_i,
  output logic [WIDTH-1:0] en_o
);
  logic [WIDTH-1:0] en_q;

  always_latch begin
    if (!rst_ni)     en_q <= '1;
    else if (!clk_i) en_q <= en_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/clk_pair_drive.sv
module clk_pair_drive
  import fanout_pkg::*;
(
  input  logic      clk_i,
  input  logic      en_i,
  input  out_mode_e mode_i,
  input  logic      pd_ni,
  output logic      t_o,
  output logic      c_o,
  output logic      oe_o
);
  logic gated;

  assign gated = clk_i & en_i;
  assign t_o   = gated;
  assign c_o   = (mode_i == MODE_COMPL) ? ~gated : gated;
  assign oe_o  = pd_ni;
endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
  import fanout_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = FANOUT_PAIRS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic                 pd_ni,
  input  logic [NUM_PAIRS-1:0] pair_en_i,
  input  logic                 fb_en_i,
  output logic [NUM_PAIRS-1:0] pair_t_o,
  output logic [NUM_PAIRS-1:0] pair_c_o,
  output logic [NUM_PAIRS-1:0] pair_oe_o,
  output logic                 fb_o,
  output logic                 fb_oe_o
);
  localparam int unsigned EN_W = NUM_PAIRS + 1;

  logic [EN_W-1:0] en_all;
  out_mode_e       mode;

  assign mode = out_mode_e'(mode_i);

  clk_en_latch #(.WIDTH(EN_W)) u_en_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   ({fb_en_i, pair_en_i}),
    .en_o   (en_all)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    clk_pair_drive u_drive (
      .clk_i  (clk_i),
      .en_i   (en_all[i]),
      .mode_i (mode),
      .pd_ni  (pd_ni),
      .t_o    (pair_t_o[i]),
      .c_o    (pair_c_o[i]),
      .oe_o   (pair_oe_o[i])
    );
  end

  // Feedback is never inverted.
  assign fb_o    = clk_i & en_all[NUM_PAIRS];
  assign fb_oe_o = pd_ni;

  // Enables seen at the rising edge, for checking the high phase.
  logic [EN_W-1:0] rise_en;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_en <= '1;
    else         rise_en <= {fb_en_i, pair_en_i};
  end

  p_power_down_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |-> (pair_oe_o == '0) && !fb_oe_o);
  p_compl_mode_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    mode_i |-> (pair_c_o == ~pair_t_o));
  p_single_mode_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !mode_i |-> (pair_c_o == pair_t_o));
  p_low_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_t_o == '0) && !fb_o);
  p_high_phase_r8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ({fb_o, pair_t_o} == rise_en));
endmodule

// File: tb/clk_fanout_gate_tb.sv
module clk_fanout_gate_tb;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode = 1'b1;
  logic         pd_n = 1'b1;
  logic [N-1:0] pair_en = '0;
  logic         fb_en = 1'b0;
  logic [N-1:0] t, c, oe;
  logic         fb, fb_oe;

  int    n_checks = 0;
  int    n_fails  = 0;
  string scen     = "R9";
  logic [N:0] model_en = '1;
  bit    done = 0;

  always #4 clk = ~clk;

  clk_fanout_gate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pd_ni(pd_n),
    .pair_en_i(pair_en), .fb_en_i(fb_en),
    .pair_t_o(t), .pair_c_o(c), .pair_oe_o(oe), .fb_o(fb), .fb_oe_o(fb_oe)
  );

  task automatic check_vec(string req, logic [N:0] act, logic [N:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s [%s] t=%0t actual=%b expected=%b", req, scen, $time, act, exp);
    end
  endtask

  task automatic compare(bit hi);
    logic [N-1:0] et, ec;
    et = hi ? model_en[N-1:0] : '0;
    ec = mode ? ~et : et;
    check_vec("R4/R5 true outputs", {1'b0, t}, {1'b0, et});
    check_vec(mode ? "R2 compl outputs" : "R3 single outputs", {1'b0, c}, {1'b0, ec});
    check_vec("R7 feedback", {{N{1'b0}}, fb}, {{N{1'b0}}, hi & model_en[N]});
    check_vec("R1 output enables", {fb_oe, oe}, {(N+1){pd_n}});
  endtask

  always @(posedge clk) begin
    model_en = rst_n ? {fb_en, pair_en} : '1;
    #2 if (!done) compare(1'b1);
  end
  always @(negedge clk) begin
    #2 if (!done) compare(1'b0);
  end

  task automatic low_drive(int cycles);
    repeat (cycles) @(negedge clk);
    #1;
  endtask

  initial begin
    // R9: enables forced on during reset
    low_drive(3);
    rst_n = 1'b1;
    scen = "R2"; pair_en = '1; fb_en = 1'b1; mode = 1'b1;
    low_drive(3);
    scen = "R3"; mode = 1'b0;
    low_drive(3);
    scen = "R5"; pair_en = 6'b101010; mode = 1'b1;
    low_drive(2);
    mode = 1'b0;
    low_drive(2);
    scen = "R6";
    for (int i = 0; i < N; i++) begin
      pair_en = 6'b1 << i;
      mode = i[0];
      low_drive(2);
    end
    scen = "R7"; pair_en = '1; fb_en = 1'b0; mode = 1'b1;
    low_drive(2);
    fb_en = 1'b1; mode = 1'b0;
    low_drive(2);
    mode = 1'b1;
    low_drive(2);
    scen = "R1"; pd_n = 1'b0; pair_en = 6'b010101;
    low_drive(3);
    pd_n = 1'b1;
    low_drive(2);
    // R8: change enables during the high phase
    scen = "R8"; pair_en = '1; fb_en = 1'b1;
    low_drive(1);
    @(posedge clk); #1 pair_en = 6'b000110; fb_en = 1'b0;
    low_drive(2);
    @(posedge clk); #1 pair_en = '1; fb_en = 1'b1;
    low_drive(2);
    mode = 1'b0;
    @(posedge clk); #1 pair_en = 6'b110000;
    low_drive(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #400000;
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule